// File: doc/BRIEF.md
# Half-Duplex Back Pressure Jam Generator

This block throttles incoming traffic on a half-duplex link. When a frame starts arriving while the receive buffer sits above its back-pressure high-water level, the block raises a jam-active strobe for a programmed time. The MAC transmit path uses that strobe to put a jam onto the medium. The strobe forces a collision, so the far end backs off and retries later.

Two mode bits decide which frames qualify:
- With the "any frame" mode set, every arriving frame qualifies.
- With the "address" mode set alone, only frames whose destination address matched qualify.

The duration comes from a 4-bit code through a non-linear table of sixteen lengths, from 5 µs to 600 µs. The jam is timed with a microsecond tick. A prescaler derives that tick from the core clock and restarts it at each trigger, so a jam lasts exactly the programmed number of whole microseconds.

A trigger that arrives during a jam is ignored. Leaving half duplex, or clearing both mode bits, ends a jam on the next clock. The block reports the remaining microseconds and the length of the current or most recent jam.

Top module: `bp_jam_gen`

## Requirements
- R1: `jam_active` is never raised while `half_duplex` is 0. Sampling `half_duplex` low at a clock edge ends an active jam at that edge.
- R2: With `mode_any`=1, a `frame_start` pulse with `above_hw`=1 starts a jam whatever `da_match` is.
- R3: A `frame_start` pulse with `above_hw`=0 never starts a jam, in either mode.
- R4: With `mode_da`=1 and `mode_any`=0, a jam starts only if `da_match`=1 in the cycle that `frame_start` is high.
- R5: With both mode bits set, the any-frame rule of R2 applies, so `da_match`=0 still triggers.
- R6: The 4-bit `jam_code` maps to these durations in µs:

  | Codes | Durations (µs) |
  |-------|----------------|
  | 0, 1, 2 | 5, 10, 15 |
  | 3 | 25 |
  | 4 | 50 |
  | 5 to 15 | 100 up to 600, in steps of 50 |

  `jam_active` rises on the clock edge that samples the trigger. It stays high for exactly the duration times CLKS_PER_US cycles. `cur_len_us` shows that duration.
- R7: While a jam is active, `us_tick` pulses once every CLKS_PER_US cycles, counting from the trigger. `jam_us_left` starts at the duration and drops by one on each tick.
- R8: A trigger during an active jam neither restarts nor extends it, and does not change `cur_len_us`.
- R9: Sampling `mode_any`=0 and `mode_da`=0 at a clock edge ends an active jam at that edge.
- R10: After reset, `jam_active`=0, `us_tick`=0 and `jam_us_left`=0. `cur_len_us`=200, the length for the reset code 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_duplex | input | 1 | 1 = link is in half duplex |
| mode_any | input | 1 | Jam on any qualifying frame |
| mode_da | input | 1 | Jam only on destination-address match |
| frame_start | input | 1 | One-cycle pulse at the start of an incoming frame |
| da_match | input | 1 | Destination address of the incoming frame matched |
| above_hw | input | 1 | Receive buffer is above the back-pressure high-water level |
| jam_code | input | 4 | Jam duration code (table in R6) |
| jam_active | output | 1 | Jam in progress |
| us_tick | output | 1 | Microsecond tick pulse during a jam |
| jam_us_left | output | 10 | Whole microseconds remaining in the jam |
| cur_len_us | output | 10 | Duration of the current or most recent jam, in µs |

## Verification
The hardest case to reach from the ports is a second trigger, carrying a different code, landing in the middle of a running jam. Only then can a restart, an extension or a reload of the length become visible. The bench starts the shortest jam and fires a new frame with the longest code a few cycles later. It then checks that the total high time and `cur_len_us` still belong to the first code.

Early termination is reached the same way. The bench drops the duplex or the mode bits partway through a long jam and checks that the strobe falls on the next edge.

// File: rtl/bpj_pkg.sv
package bpj_pkg;
  localparam int US_W   = 10;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] RESET_CODE = 4'd7;

  // Duration in microseconds for a jam code.
  function automatic logic [US_W-1:0] code_to_us(input logic [CODE_W-1:0] code);
    logic [US_W-1:0] c;
    c = US_W'(code);
    if (code <= 4'd2)      code_to_us = US_W'(5) * (c + US_W'(1));
    else if (code == 4'd3) code_to_us = US_W'(25);
    else if (code == 4'd4) code_to_us = US_W'(50);
    else                   code_to_us = US_W'(50) * (c - US_W'(3));
  endfunction
endpackage

// File: rtl/bpj_qualify.sv
module bpj_qualify (
  input  logic half_duplex,
  input  logic mode_any,
  input  logic mode_da,
  input  logic frame_start,
  input  logic da_match,
  input  logic above_hw,
  input  logic busy,
  output logic trig,
  output logic abort
);
  logic frame_ok;

  always_comb begin
    // The any-frame mode takes precedence when both mode bits are set.
    frame_ok = mode_any | (mode_da & da_match);
    trig     = half_duplex & frame_start & above_hw & frame_ok & ~busy;
    abort    = busy & (~half_duplex | ~(mode_any | mode_da));
  end
endmodule

// File: rtl/bpj_prescaler.sv
module bpj_prescaler #(
  parameter int CLKS_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int CW = $clog2(CLKS_PER_US + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr || !run)         cnt <= '0;
    else if (cnt == LAST)         cnt <= '0;
    else                          cnt <= cnt + CW'(1);
  end

  assign tick = run & (cnt == LAST);
endmodule

// File: rtl/bpj_timer.sv
module bpj_timer
  import bpj_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic            tick,
  input  logic [US_W-1:0] dur_us,
  output logic            active,
  output logic [US_W-1:0] left_us,
  output logic [US_W-1:0] len_us
);
  logic last_tick;
  assign last_tick = tick & (left_us == US_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      left_us <= '0;
      len_us  <= code_to_us(RESET_CODE);
    end else if (start) begin
      active  <= 1'b1;
      left_us <= dur_us;
      len_us  <= dur_us;
    end else if (abort || last_tick) begin
      active  <= 1'b0;
      left_us <= '0;
    end else if (tick) begin
      left_us <= left_us - US_W'(1);
    end
  end
endmodule

// File: rtl/bp_jam_gen.sv
module bp_jam_gen
  import bpj_pkg::*;
#(
  parameter int CLKS_PER_US = 125
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              half_duplex,
  input  logic              mode_any,
  input  logic              mode_da,
  input  logic              frame_start,
  input  logic              da_match,
  input  logic              above_hw,
  input  logic [CODE_W-1:0] jam_code,
  output logic              jam_active,
  output logic              us_tick,
  output logic [US_W-1:0]   jam_us_left,
  output logic [US_W-1:0]   cur_len_us
);
  // Named internal events, visible to the bound checker.
  logic            trig;
  logic            abort;
  logic [US_W-1:0] dur_us;

  assign dur_us = code_to_us(jam_code);

  bpj_qualify u_qual (
    .half_duplex (half_duplex),
    .mode_any    (mode_any),
    .mode_da     (mode_da),
    .frame_start (frame_start),
    .da_match    (da_match),
    .above_hw    (above_hw),
    .busy        (jam_active),
    .trig        (trig),
    .abort       (abort)
  );

  bpj_prescaler #(.CLKS_PER_US(CLKS_PER_US)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (jam_active),
    .clr   (trig),
    .tick  (us_tick)
  );

  bpj_timer u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (trig),
    .abort   (abort),
    .tick    (us_tick),
    .dur_us  (dur_us),
    .active  (jam_active),
    .left_us (jam_us_left),
    .len_us  (cur_len_us)
  );
endmodule

// File: rtl/bpj_checker.sv
module bpj_checker
  import bpj_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            half_duplex,
  input logic            mode_any,
  input logic            mode_da,
  input logic            frame_start,
  input logic            above_hw,
  input logic            trig,
  input logic            jam_active,
  input logic            us_tick,
  input logic [US_W-1:0] jam_us_left,
  input logic [US_W-1:0] cur_len_us
);
  assert_no_jam_full_duplex_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !half_duplex |=> !jam_active);

  assert_rise_needs_buffer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> $past(frame_start && above_hw && half_duplex));

  assert_end_on_last_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(jam_active) && $past(half_duplex) && $past(mode_any || mode_da))
      |-> ($past(us_tick) && $past(jam_us_left) == US_W'(1)));

  assert_left_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jam_active |-> jam_us_left != '0);

  assert_tick_only_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    us_tick |-> jam_active);

  assert_no_extend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (jam_active && $past(jam_active)) |-> (jam_us_left <= $past(jam_us_left) && $stable(cur_len_us)));

  assert_no_trig_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jam_active |-> !trig);

  assert_modes_off_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_any && !mode_da) |=> !jam_active);
endmodule

bind bp_jam_gen bpj_checker i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .half_duplex (half_duplex),
  .mode_any    (mode_any),
  .mode_da     (mode_da),
  .frame_start (frame_start),
  .above_hw    (above_hw),
  .trig        (trig),
  .jam_active  (jam_active),
  .us_tick     (us_tick),
  .jam_us_left (jam_us_left),
  .cur_len_us  (cur_len_us)
);

// File: tb/test_bp_jam_gen.sv
module test_bp_jam_gen;
  localparam int CPU = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_duplex = 1'b1, mode_any = 1'b0, mode_da = 1'b0;
  logic       frame_start = 1'b0, da_match = 1'b0, above_hw = 1'b0;
  logic [3:0] jam_code = 4'd7;
  logic       jam_active, us_tick;
  logic [9:0] jam_us_left, cur_len_us;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  bp_jam_gen #(.CLKS_PER_US(CPU)) i_bp_jam_gen (
    .clk(clk), .rst_n(rst_n), .half_duplex(half_duplex), .mode_any(mode_any),
    .mode_da(mode_da), .frame_start(frame_start), .da_match(da_match),
    .above_hw(above_hw), .jam_code(jam_code), .jam_active(jam_active),
    .us_tick(us_tick), .jam_us_left(jam_us_left), .cur_len_us(cur_len_us)
  );

  function automatic int table_us(input int c);
    int t[16] = '{5, 10, 15, 25, 50, 100, 150, 200, 250, 300, 350, 400, 450, 500, 550, 600};
    return t[c];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse frame_start for one cycle; returns at the following negedge.
  task automatic pulse(input logic match);
    @(negedge clk);
    frame_start = 1'b1;
    da_match = match;
    @(negedge clk);
    frame_start = 1'b0;
    da_match = 1'b0;
  endtask

  // Count cycles of jam_active from now, plus ticks seen.
  task automatic measure(output int len, output int ticks);
    len = 0;
    ticks = 0;
    while (jam_active && len < 5000) begin
      len++;
      if (us_tick) ticks++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int len, tk;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 active", int'(jam_active), 0);
    check("R10 tick", int'(us_tick), 0);
    check("R10 left", int'(jam_us_left), 0);
    check("R10 len", int'(cur_len_us), 200);
    rst_n = 1'b1;
    @(negedge clk);

    // R6/R2 sweep every code in any-frame mode
    mode_any = 1'b1;
    above_hw = 1'b1;
    for (int c = 0; c < 16; c++) begin
      jam_code = 4'(c);
      pulse(1'b0);
      check("R6 left at start", int'(jam_us_left), table_us(c));
      check("R6 cur_len", int'(cur_len_us), table_us(c));
      measure(len, tk);
      check("R6 length cycles", len, table_us(c) * CPU);
      check("R7 tick count", tk, table_us(c));
      @(negedge clk);
    end

    // R7 countdown after one tick
    jam_code = 4'd1;
    pulse(1'b0);
    repeat (CPU) @(negedge clk);
    check("R7 left after one tick", int'(jam_us_left), 9);
    measure(len, tk);

    // R3 buffer below high water: no jam
    above_hw = 1'b0;
    pulse(1'b1);
    check("R3 any mode", int'(jam_active), 0);
    mode_any = 1'b0;
    mode_da = 1'b1;
    pulse(1'b1);
    check("R3 da mode", int'(jam_active), 0);
    above_hw = 1'b1;

    // R4 address mode
    jam_code = 4'd0;
    pulse(1'b0);
    check("R4 no match", int'(jam_active), 0);
    pulse(1'b1);
    check("R4 match", int'(jam_active), 1);
    measure(len, tk);
    check("R4 length", len, 5 * CPU);

    // R5 both bits set: any-frame rule
    mode_any = 1'b1;
    pulse(1'b0);
    check("R5 both bits", int'(jam_active), 1);
    measure(len, tk);

    // R1 full duplex: no jam
    half_duplex = 1'b0;
    pulse(1'b1);
    check("R1 full duplex trigger", int'(jam_active), 0);
    half_duplex = 1'b1;

    // R8 retrigger during jam
    jam_code = 4'd0;
    pulse(1'b0);
    repeat (7) @(negedge clk);
    jam_code = 4'd15;
    pulse(1'b1);
    check("R8 cur_len kept", int'(cur_len_us), 5);
    measure(len, tk);
    check("R8 total length", len + 9, 5 * CPU);

    // R1 abort by leaving half duplex
    jam_code = 4'd15;
    pulse(1'b0);
    repeat (10) @(negedge clk);
    half_duplex = 1'b0;
    @(negedge clk);
    check("R1 abort", int'(jam_active), 0);
    check("R1 abort left", int'(jam_us_left), 0);
    half_duplex = 1'b1;

    // R9 abort by clearing mode bits
    pulse(1'b0);
    repeat (10) @(negedge clk);
    mode_any = 1'b0;
    mode_da = 1'b0;
    @(negedge clk);
    check("R9 abort", int'(jam_active), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule